// File: doc/BRIEF.md
# Stereo Audio Codec Clock Generator and Serializer

This block drives the playback side of an external stereo audio codec from one reference clock that runs at 384 times the sample rate. The reference clock is inverted and sent out as the codec master clock. A divide-by-four gives the bit clock. A word-select clock toggles once every 48 bit periods, which gives a 96-bit frame with the left half first.

A host pushes 16-bit samples into a small FIFO through a valid/ready port. The host always pushes the left sample of a frame first and the right sample second. The FIFO takes up uneven host timing, so the serial stream stays on a fixed grid.

Each channel sample leaves MSB first, one bit period after the word-select edge. A frame is only played when both of its samples are already queued. If they are not, the block sends a silent frame and pulses an underflow flag.

Back-pressure: `in_ready` is high exactly when the FIFO has room. A word is taken on a clock where `in_valid` and `in_ready` are both high. A word offered while `in_ready` is low is discarded, not held, and the block raises an overflow pulse.

Top module: `acodec_tx`

## Requirements
- R1: `codec_mclk` is the logical inverse of `clk` at all times.
- R2: `codec_bclk` has a period of `BCLK_DIV` (default 4) reference cycles: low for the first half, high for the second half.
- R3: `codec_lrclk` changes only together with a falling edge of `codec_bclk`, and holds each level for exactly `SLOT_BITS` (default 48) bit periods. Level 0 marks the left channel and level 1 the right channel.
- R4: In each channel slot, the bit periods numbered 1 to 16 after the word-select edge carry the channel's sample, MSB first. Samples play in the order they were accepted, alternating left then right.
- R5: Bit period 0 of every slot, and bit periods 17 to `SLOT_BITS`-1, carry 0.
- R6: `codec_sdata` changes only at falling edges of `codec_bclk`, so it is stable while `codec_bclk` is high.
- R7: `in_ready` is high exactly when the FIFO (depth `FIFO_DEPTH`) is not full. A word is accepted on a clock with `in_valid` and `in_ready` both high.
- R8: A word offered while `in_ready` is low is dropped and never played. `ovf_pulse` is high for the one cycle after that offer.
- R9: A left slot starts a frame only if at least two words are queued. Otherwise both channels of that frame are all zeros, nothing is dequeued, and `unf_pulse` is high for one cycle.
- R10: During reset, `codec_bclk` is 0, `codec_lrclk` is 1, `codec_sdata` is 0, `in_ready` is 1, and both pulses are 0. The first slot after reset is a left slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, 384 times the sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Host offers a sample |
| in_ready | output | 1 | FIFO has room for a sample |
| in_data | input | 16 | Sample word, left and right alternating |
| codec_mclk | output | 1 | Codec master clock, inverted reference |
| codec_bclk | output | 1 | Serial bit clock |
| codec_lrclk | output | 1 | Word select: 0 left, 1 right |
| codec_sdata | output | 1 | Serial sample data |
| ovf_pulse | output | 1 | One-cycle pulse: a word was dropped |
| unf_pulse | output | 1 | One-cycle pulse: a silent frame was started |

## Verification
The bench keeps the default divider of 4 and the 48-bit slot, so the real frame grid of 384 reference cycles is what gets checked. It shrinks `FIFO_DEPTH` to 8, so the FIFO can be filled within a single channel slot. That makes the full condition, the dropped words and the overflow pulse reachable before any dequeue interferes. With only 8 entries, a single left word stalled in the queue is also easy to watch across several silent frames.

// File: rtl/acodec_pkg.sv
package acodec_pkg;
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

  localparam int FRAME_CHANNELS = 2;
endpackage

// File: rtl/acodec_bclk_div.sv
module acodec_bclk_div #(
  parameter int BCLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic bclk,
  output logic tick
);
  localparam int CW   = (BCLK_DIV > 2) ? $clog2(BCLK_DIV) : 1;
  localparam int HALF = BCLK_DIV / 2;
  localparam logic [CW-1:0] LAST  = CW'(BCLK_DIV - 1);
  localparam logic [CW-1:0] HIGHS = CW'(HALF);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      bclk  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      bclk  <= (cnt_d >= HIGHS);
    end
  end

  assign tick = (cnt_q == LAST);

  p_bclk_falls_after_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!bclk && $past(bclk)));
endmodule

// File: rtl/acodec_frame_seq.sv
module acodec_frame_seq #(
  parameter int SLOT_BITS = 48
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  output logic                         lrclk,
  output logic [$clog2(SLOT_BITS)-1:0] pos,
  output logic [$clog2(SLOT_BITS)-1:0] next_pos,
  output logic                         left_start,
  output logic                         right_start
);
  localparam int PW = $clog2(SLOT_BITS);
  localparam logic [PW-1:0] LAST = PW'(SLOT_BITS - 1);

  logic wrap;

  assign wrap        = (pos == LAST);
  assign next_pos    = wrap ? '0 : pos + 1'b1;
  assign left_start  = tick && wrap && lrclk;
  assign right_start = tick && wrap && !lrclk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos   <= LAST;
      lrclk <= 1'b1;
    end else if (tick) begin
      pos <= next_pos;
      if (wrap) lrclk <= ~lrclk;
    end
  end
endmodule

// File: rtl/acodec_fifo.sv
module acodec_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_valid,
  output logic                       wr_ready,
  input  logic [W-1:0]               wr_data,
  input  logic                       pop,
  output logic [W-1:0]               rd_data,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push;

  assign wr_ready = (level != FULL);
  assign push     = wr_valid && wr_ready;
  assign rd_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  p_level_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL);
  p_pop_not_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (level != '0));
endmodule

// File: rtl/acodec_shifter.sv
module acodec_shifter #(
  parameter int W         = 16,
  parameter int SLOT_BITS = 48
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic                         bclk,
  input  logic [$clog2(SLOT_BITS)-1:0] next_pos,
  input  logic                         load,
  input  logic [W-1:0]                 load_data,
  output logic                         sdata
);
  localparam int PW = $clog2(SLOT_BITS);
  localparam logic [PW-1:0] DATA_LAST = PW'(W);

  logic [W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg  <= '0;
      sdata <= 1'b0;
    end else if (tick) begin
      if (next_pos == '0) begin
        sreg  <= load ? load_data : '0;
        sdata <= 1'b0;
      end else if (next_pos <= DATA_LAST) begin
        sdata <= sreg[W-1];
        sreg  <= {sreg[W-2:0], 1'b0};
      end else begin
        sdata <= 1'b0;
      end
    end
  end

  p_sdata_hold_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk && $past(bclk)) |-> $stable(sdata));
endmodule

// File: rtl/acodec_tx.sv
module acodec_tx #(
  parameter int SAMPLE_W   = 16,
  parameter int BCLK_DIV   = 4,
  parameter int SLOT_BITS  = 48,
  parameter int FIFO_DEPTH = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                codec_mclk,
  output logic                codec_bclk,
  output logic                codec_lrclk,
  output logic                codec_sdata,
  output logic                ovf_pulse,
  output logic                unf_pulse
);
  import acodec_pkg::*;

  localparam int PW = $clog2(SLOT_BITS);
  localparam int LW = $clog2(FIFO_DEPTH + 1);
  localparam logic [LW-1:0] PAIR = LW'(FRAME_CHANNELS);

  logic          tick, left_start, right_start, frame_live, pop, have_pair;
  logic [PW-1:0] pos, next_pos;
  logic [LW-1:0] level;
  logic [SAMPLE_W-1:0] head;
  chan_e         cur_chan;

  assign codec_mclk = ~clk;

  acodec_bclk_div #(.BCLK_DIV(BCLK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .bclk(codec_bclk), .tick(tick)
  );

  acodec_frame_seq #(.SLOT_BITS(SLOT_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .lrclk(codec_lrclk),
    .pos(pos), .next_pos(next_pos),
    .left_start(left_start), .right_start(right_start)
  );

  acodec_fifo #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(in_valid), .wr_ready(in_ready),
    .wr_data(in_data), .pop(pop), .rd_data(head), .level(level)
  );

  acodec_shifter #(.W(SAMPLE_W), .SLOT_BITS(SLOT_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bclk(codec_bclk),
    .next_pos(next_pos), .load(pop), .load_data(head), .sdata(codec_sdata)
  );

  assign cur_chan  = chan_e'(codec_lrclk);
  assign have_pair = (level >= PAIR);
  assign pop       = (left_start && have_pair) || (right_start && frame_live);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_live <= 1'b0;
      ovf_pulse  <= 1'b0;
      unf_pulse  <= 1'b0;
    end else begin
      ovf_pulse <= in_valid && !in_ready;
      unf_pulse <= left_start && !have_pair;
      if (left_start) frame_live <= have_pair;
    end
  end

  p_lr_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(codec_lrclk) |-> $fell(codec_bclk));
  p_drop_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> ovf_pulse);
  p_gap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (codec_bclk && pos == '0) |-> !codec_sdata);
  p_right_pop_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && cur_chan == CH_LEFT) |-> frame_live);
endmodule

// File: tb/acodec_tx_test.sv
module acodec_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16, DIV = 4, SLOT = 48, DEPTH = 8;
  localparam int FRAME_CYC = 2 * SLOT * DIV;
  localparam int WATCHDOG = 150000;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [W-1:0] in_data = '0;
  logic in_ready, mclk, bclk, lrclk, sdata, ovf, unf;

  int tests = 0, fails = 0, silent = 0, unf_cnt = 0;
  bit done = 0;
  logic [W-1:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  acodec_tx #(.SAMPLE_W(W), .BCLK_DIV(DIV), .SLOT_BITS(SLOT), .FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .codec_mclk(mclk), .codec_bclk(bclk),
    .codec_lrclk(lrclk), .codec_sdata(sdata), .ovf_pulse(ovf), .unf_pulse(unf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: rebuilds slots at bit clock rises and scores frames
  logic prev_bclk = 0, prev_sdata = 0, cur_lr = 1, have_slot = 0, have_left = 0;
  int gap = 0, bits = 0;
  logic [W-1:0] word = '0, lword = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (unf) unf_cnt++;
      chk(mclk == 1'b1, "R1", mclk, 1);
      if (bclk && prev_bclk) chk(sdata == prev_sdata, "R6", sdata, prev_sdata);
      gap++;
      if (bclk && !prev_bclk) begin
        if (have_slot) chk(gap == DIV, "R2", gap, DIV);
        gap = 0;
        if (lrclk != cur_lr) begin
          if (have_slot) begin
            chk(bits == SLOT, "R3", bits, SLOT);
            if (cur_lr == 1'b0) begin
              lword = word; have_left = 1;
            end else if (have_left) begin
              if (lword == 0 && word == 0) silent++;
              else if (expq.size() < 2) chk(0, "R4 no sample pending", word, 0);
              else begin
                logic [W-1:0] el, er;
                el = expq.pop_front(); er = expq.pop_front();
                chk(lword == el, "R4 left", lword, el);
                chk(word == er, "R4 right", word, er);
              end
            end
          end else chk(lrclk == 1'b0, "R10 first slot left", lrclk, 0);
          have_slot = 1; bits = 0; word = '0; cur_lr = lrclk;
        end
        if (bits >= 1 && bits <= W) word = {word[W-2:0], sdata};
        else if (have_slot) chk(sdata == 1'b0, "R5", sdata, 0);
        bits++;
      end
    end
    prev_bclk = bclk; prev_sdata = sdata;
  end

  task automatic send(input logic [W-1:0] d);
    logic r;
    in_valid = 1; in_data = d; r = in_ready;
    @(posedge clk); @(negedge clk);
    if (r) expq.push_back(d);
    chk(ovf == !r, "R8 overflow pulse", ovf, !r);
    in_valid = 0;
  endtask

  task automatic send_wait(input logic [W-1:0] d);
    while (!in_ready) @(negedge clk);
    send(d);
  endtask

  task automatic drain();
    int n = 0;
    while (expq.size() != 0 && n < 40) begin
      repeat (FRAME_CYC) @(negedge clk);
      n++;
    end
    repeat (2 * FRAME_CYC) @(negedge clk);
  endtask

  initial begin
    int u0, s0, pend;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(bclk == 0, "R10 bclk", bclk, 0);
    chk(lrclk == 1, "R10 lrclk", lrclk, 1);
    chk(sdata == 0, "R10 sdata", sdata, 0);
    chk(in_ready == 1, "R10 ready", in_ready, 1);
    chk(ovf == 0 && unf == 0, "R10 flags", {ovf, unf}, 0);
    chk(mclk == 1, "R1 during reset", mclk, 1);
    rst_n = 1;
    repeat (12) @(negedge clk);
    chk(unf_cnt >= 1, "R9 underflow after reset", unf_cnt, 1);
    @(posedge clk); #1 chk(mclk == 0, "R1 high phase", mclk, 0);
    @(negedge clk);

    // R4 main data patterns, left then right
    send_wait(16'h8001); send_wait(16'h7FFE);
    send_wait(16'hFFFF); send_wait(16'h0001);
    send_wait(16'hA5A5); send_wait(16'h5A5A);
    send_wait(16'h8000); send_wait(16'h1234);
    send_wait(16'hFEDC); send_wait(16'h0F0F);
    send_wait(16'h4000); send_wait(16'h0002);
    drain();
    chk(expq.size() == 0, "R4 all pairs played", expq.size(), 0);

    // R9 lone left word must not start a frame
    u0 = unf_cnt; s0 = silent;
    send_wait(16'hC3C3);
    repeat (3 * FRAME_CYC) @(negedge clk);
    pend = expq.size();
    chk(pend == 1, "R9 lone word held", pend, 1);
    chk(unf_cnt > u0, "R9 underflow pulses", unf_cnt - u0, 1);
    chk(silent > s0, "R9 silent frames", silent - s0, 1);
    send_wait(16'h3C3C);
    drain();
    chk(expq.size() == 0, "R9 pair after stall", expq.size(), 0);

    // R7/R8 fill to full within one right slot, extra words dropped
    @(negedge clk);
    while (!(lrclk == 1 && bits == 1)) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin
      chk(in_ready == 1, "R7 ready while room", in_ready, 1);
      send(16'h1100 + 16'(i + 1));
    end
    chk(in_ready == 0, "R7 ready low when full", in_ready, 0);
    send(16'hDEAD);
    send(16'hBEEF);
    chk(expq.size() == DEPTH, "R8 dropped not queued", expq.size(), DEPTH);
    drain();
    chk(expq.size() == 0, "R8 dropped words never played", expq.size(), 0);
    chk(in_ready == 1, "R7 ready after drain", in_ready, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule